// File: doc/BRIEF.md
# Block Address Translation Matcher

This block holds two banks of eight block-translation register pairs, one bank for instruction fetches and one for data accesses. Each pair is an upper word (block effective base, block-length field and two valid bits, one per privilege level) and a lower word (block physical base). A lookup presents an effective address, a side select, the privilege level and the relocation enable for that side. The block compares the address against every pair of the selected bank in parallel and returns a hit flag and a page-aligned physical address on the next clock.

Software reaches the registers through a port addressed by a 10-bit special-purpose register number. The number is decoded into side, entry index and upper/lower word; numbers outside the block's window read as zero and ignore writes. Every accepted write raises a one-cycle flush pulse so that downstream translation caches drop entries built from the old contents. With relocation disabled, the address passes through as its own physical page and is reported as a hit.

Top module: `bat_xlate`

## Requirements
- R1: After reset every register reads zero, no entry is valid, and a translated lookup misses.
- R2: A register number is accepted when its bits 9:6 equal 4'b1000; bit 3 selects the side (0 instruction, 1 data), the entry index is {bit 5, bit 2, bit 1}, and bit 0 selects the upper (0) or lower (1) word. A read returns the stored word in the same cycle.
- R3: A read of a number outside the window returns zero; a write to one changes no register and raises no flush.
- R4: Each accepted write sets `flush_o` high for exactly the one cycle after the write.
- R5: When `xlate_en_i` is low, the next cycle shows `hit_o` high and `pa_o` equal to `ea_i` with bits 11:0 cleared.
- R6: In supervisor mode (`user_i` = 0) an entry takes part only if upper bit 1 is set; in user mode only if upper bit 0 is set.
- R7: The block-length field is upper bits 12:2; the compare mask is that field inverted, zero-extended to 32 bits before inversion, shifted left by 17. An entry matches when `ea_i` AND mask equals the upper word with bits 16:0 cleared.
- R8: On a hit, `pa_o` = (lower word with bits 16:0 cleared) + (`ea_i` with bits 11:0 cleared) − (upper word with bits 16:0 cleared), modulo 2^32.
- R9: When several entries match, the lowest index supplies the result.
- R10: `side_i` picks the bank; entries of the other bank never produce a hit.
- R11: Lookup results are registered one cycle after the inputs; on a miss `hit_o` is 0 and `pa_o` is 0.
- R12: A lookup in the same cycle as a register write is judged against the contents before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spr_we_i | input | 1 | Register write strobe |
| spr_num_i | input | 10 | Register number for read and write |
| spr_wdata_i | input | 32 | Write data |
| spr_rdata_o | output | 32 | Read data for `spr_num_i` |
| flush_o | output | 1 | One-cycle pulse after an accepted write |
| ea_i | input | 32 | Effective address to translate |
| side_i | input | 1 | 0 instruction bank, 1 data bank |
| user_i | input | 1 | 1 user mode, 0 supervisor mode |
| xlate_en_i | input | 1 | Relocation enable for the selected side |
| hit_o | output | 1 | Registered hit flag |
| pa_o | output | 32 | Registered page-aligned physical address |

## Verification
A register write and a lookup can fall in the same cycle, and the lookup must see the bank as it was before the write while the flush pulse follows one cycle later. The bench provokes this by clearing the valid bits of a matching data entry in the same cycle as a lookup that hits it, expecting the old physical address on the next cycle and a miss on the one after. Other cases cover privilege selection, block-length edges, priority between overlapping entries, and an out-of-window number whose low bits alias a live register.

// File: rtl/bat_xlate_pkg.sv
package bat_xlate_pkg;
  localparam int XLEN     = 32;
  localparam int PAGE_SH  = 12;
  localparam int BLK_SH   = 17;
  localparam int BL_LSB   = 2;
  localparam int BL_W     = 11;
  localparam int SPR_W    = 10;
  localparam int NUM_ENT  = 8;
  localparam int IDX_W    = $clog2(NUM_ENT);
  localparam int NUM_SIDE = 2;
  localparam int TAG_LSB  = 6;
  localparam int TAG_W    = SPR_W - TAG_LSB;
  localparam logic [TAG_W-1:0] SPR_TAG = 4'b1000;
  localparam int VS_BIT   = 1;
  localparam int VP_BIT   = 0;

  typedef logic [XLEN-1:0] word_t;

  typedef struct packed {
    logic             ok;
    logic             side;
    logic [IDX_W-1:0] idx;
    logic             lower;
  } spr_dec_t;
endpackage

// File: rtl/bat_spr_decode.sv
module bat_spr_decode
  import bat_xlate_pkg::*;
(
  input  logic [SPR_W-1:0] spr_i,
  output spr_dec_t         dec_o
);
  logic unused_spr;
  assign unused_spr = spr_i[4];

  always_comb begin
    dec_o.ok    = (spr_i[SPR_W-1:TAG_LSB] == SPR_TAG);
    dec_o.side  = spr_i[3];
    dec_o.idx   = {spr_i[5], spr_i[2:1]};
    dec_o.lower = spr_i[0];
  end
endmodule

// File: rtl/bat_bank.sv
module bat_bank
  import bat_xlate_pkg::*;
#(
  parameter int N = NUM_ENT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             lower_i,
  input  word_t            wdata_i,
  output word_t            upper_o [N],
  output word_t            lower_o [N]
);
  for (genvar e = 0; e < N; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        upper_o[e] <= '0;
        lower_o[e] <= '0;
      end else if (we_i && (idx_i == IDX_W'(e))) begin
        if (lower_i) lower_o[e] <= wdata_i;
        else         upper_o[e] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/bat_match.sv
module bat_match
  import bat_xlate_pkg::*;
#(
  parameter int N = NUM_ENT
) (
  input  word_t upper_i [N],
  input  word_t lower_i [N],
  input  word_t ea_i,
  input  logic  user_i,
  output logic  hit_o,
  output word_t pa_o
);
  localparam word_t BLK_MASK  = ~((word_t'(1) << BLK_SH) - 1);
  localparam word_t PAGE_MASK = ~((word_t'(1) << PAGE_SH) - 1);

  logic [1:0] vsel;
  logic [N-1:0] match;
  word_t pa_e [N];

  // supervisor checks bit 1, user checks bit 0
  assign vsel = {~user_i, user_i};

  for (genvar e = 0; e < N; e++) begin : g_cmp
    word_t bl_x, mask, bepi, brpn;
    logic  vld;
    logic  unused_bits;
    assign bl_x = word_t'(upper_i[e][BL_LSB +: BL_W]);
    assign mask = (~bl_x) << BLK_SH;
    assign bepi = upper_i[e] & BLK_MASK;
    assign brpn = lower_i[e] & BLK_MASK;
    assign vld  = |(upper_i[e][VS_BIT:VP_BIT] & vsel);
    assign match[e] = vld && ((ea_i & mask) == bepi);
    assign pa_e[e]  = brpn + ((ea_i & PAGE_MASK) - bepi);
    assign unused_bits = ^{upper_i[e][BLK_SH-1:BL_LSB+BL_W], lower_i[e][BLK_SH-1:0]};
  end

  // lowest index wins
  always_comb begin
    pa_o = '0;
    for (int e = N - 1; e >= 0; e--) begin
      if (match[e]) pa_o = pa_e[e];
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
  import bat_xlate_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             spr_we_i,
  input  logic [SPR_W-1:0] spr_num_i,
  input  logic [XLEN-1:0]  spr_wdata_i,
  output logic [XLEN-1:0]  spr_rdata_o,
  output logic             flush_o,
  input  logic [XLEN-1:0]  ea_i,
  input  logic             side_i,
  input  logic             user_i,
  input  logic             xlate_en_i,
  output logic             hit_o,
  output logic [XLEN-1:0]  pa_o
);
  spr_dec_t dec;
  word_t    up_q [NUM_SIDE][NUM_ENT];
  word_t    lo_q [NUM_SIDE][NUM_ENT];
  logic [NUM_SIDE-1:0] side_hit;
  word_t    side_pa [NUM_SIDE];
  logic     hit_d;
  word_t    pa_d;
  logic     unused_ea;

  assign unused_ea = ^ea_i[PAGE_SH-1:0];

  bat_spr_decode u_dec (
    .spr_i (spr_num_i),
    .dec_o (dec)
  );

  for (genvar s = 0; s < NUM_SIDE; s++) begin : g_side
    bat_bank #(.N(NUM_ENT)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (spr_we_i && dec.ok && (dec.side == 1'(s))),
      .idx_i   (dec.idx),
      .lower_i (dec.lower),
      .wdata_i (spr_wdata_i),
      .upper_o (up_q[s]),
      .lower_o (lo_q[s])
    );

    bat_match #(.N(NUM_ENT)) u_match (
      .upper_i (up_q[s]),
      .lower_i (lo_q[s]),
      .ea_i    (ea_i),
      .user_i  (user_i),
      .hit_o   (side_hit[s]),
      .pa_o    (side_pa[s])
    );
  end

  always_comb begin
    spr_rdata_o = '0;
    if (dec.ok) begin
      spr_rdata_o = dec.lower ? lo_q[dec.side][dec.idx] : up_q[dec.side][dec.idx];
    end
  end

  always_comb begin
    if (!xlate_en_i) begin
      hit_d = 1'b1;
      pa_d  = {ea_i[XLEN-1:PAGE_SH], {PAGE_SH{1'b0}}};
    end else begin
      hit_d = side_hit[side_i];
      pa_d  = side_pa[side_i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o   <= 1'b0;
      pa_o    <= '0;
      flush_o <= 1'b0;
    end else begin
      hit_o   <= hit_d;
      pa_o    <= pa_d;
      flush_o <= spr_we_i && dec.ok;
    end
  end
endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk
  import bat_xlate_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             spr_we_i,
  input logic [SPR_W-1:0] spr_num_i,
  input logic [XLEN-1:0]  spr_rdata_o,
  input logic             flush_o,
  input logic [XLEN-1:0]  ea_i,
  input logic             xlate_en_i,
  input logic             hit_o,
  input logic [XLEN-1:0]  pa_o
);
  a_r4_flush_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spr_we_i && spr_num_i[SPR_W-1:TAG_LSB] == SPR_TAG) |=> flush_o);

  a_r3_no_flush_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spr_we_i && spr_num_i[SPR_W-1:TAG_LSB] != SPR_TAG) |=> !flush_o);

  a_r4_flush_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(spr_we_i));

  a_r3_outside_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spr_num_i[SPR_W-1:TAG_LSB] != SPR_TAG) |-> spr_rdata_o == '0);

  a_r5_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xlate_en_i |=> (hit_o && pa_o == {$past(ea_i[XLEN-1:PAGE_SH]), {PAGE_SH{1'b0}}}));

  a_r11_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> pa_o == '0);

  a_r8_page_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> pa_o[PAGE_SH-1:0] == '0);
endmodule

bind bat_xlate bat_xlate_chk u_chk (.*);

// File: tb/bat_xlate_test.sv
module bat_xlate_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        spr_we_i = 1'b0;
  logic [9:0]  spr_num_i = '0;
  logic [31:0] spr_wdata_i = '0;
  logic [31:0] spr_rdata_o;
  logic        flush_o;
  logic [31:0] ea_i = '0;
  logic        side_i = 1'b0;
  logic        user_i = 1'b0;
  logic        xlate_en_i = 1'b1;
  logic        hit_o;
  logic [31:0] pa_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  bat_xlate uut (.*);

  always #4 clk_i = ~clk_i;

  // {ea, side, user, en, exp_hit, exp_pa}
  localparam int NV = 12;
  localparam logic [67:0] VEC [NV] = '{
    {32'h0012_3456, 1'b0, 1'b0, 1'b1, 1'b1, 32'h1012_3000}, // R8 instr block
    {32'h0012_3456, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0},         // R6 user, Vp clear
    {32'h0020_0000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},         // R7 past 2 MB block
    {32'h001F_FFFF, 1'b0, 1'b0, 1'b1, 1'b1, 32'h101F_F000}, // R7 last page in block
    {32'h8001_F123, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0401_F000}, // R8 data block
    {32'h8001_F123, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0},         // R6 supervisor, Vs clear
    {32'h8002_0000, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0},         // R7 past 128 KB block
    {32'h8001_F123, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0},         // R10 wrong bank
    {32'h0001_2ABC, 1'b0, 1'b0, 1'b1, 1'b1, 32'h1001_2000}, // R9 entries 0,1,4 overlap
    {32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 1'b1, 32'hDEAD_B000}, // R5 data passthrough
    {32'h0000_0FFF, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0},         // R5 instr passthrough
    {32'h0001_2000, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0}          // R10 data bank empty here
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic spr_wr(logic [9:0] num, logic [31:0] data);
    @(negedge clk_i);
    spr_we_i = 1'b1; spr_num_i = num; spr_wdata_i = data;
    @(negedge clk_i);
    spr_we_i = 1'b0;
  endtask

  task automatic spr_rd(logic [9:0] num, output logic [31:0] data);
    @(negedge clk_i);
    spr_num_i = num;
    #1 data = spr_rdata_o;
  endtask

  task automatic look(logic [31:0] ea, logic side, logic user, logic en);
    @(negedge clk_i);
    ea_i = ea; side_i = side; user_i = user; xlate_en_i = en;
    @(negedge clk_i);
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    spr_rd(10'd528, rd); check("R1 upper reads zero", rd, 32'h0);
    look(32'h0000_0000, 1'b0, 1'b0, 1'b1);
    check("R1 hit after reset", 32'(hit_o), 32'h0);
    check("R1 pa after reset", pa_o, 32'h0);
    check("R1 no flush after reset", 32'(flush_o), 32'h0);

    // program banks
    spr_wr(10'd528, 32'h0000_003E);  // instr 0: 2 MB, Vs
    spr_wr(10'd529, 32'h1000_0000);
    spr_wr(10'd536, 32'h8000_0001);  // data 0: 128 KB, Vp
    spr_wr(10'd537, 32'h0400_0000);
    spr_wr(10'd560, 32'h0000_0002);  // instr 4 via bit 5
    spr_wr(10'd561, 32'h2000_0000);
    spr_wr(10'd530, 32'h0000_0002);  // instr 1
    spr_wr(10'd531, 32'h3000_0000);

    // R2 decode and readback
    spr_rd(10'd560, rd); check("R2 instr4 upper", rd, 32'h0000_0002);
    spr_rd(10'd561, rd); check("R2 instr4 lower", rd, 32'h2000_0000);
    spr_rd(10'd537, rd); check("R2 data0 lower", rd, 32'h0400_0000);

    for (int i = 0; i < NV; i++) begin
      look(VEC[i][67:36], VEC[i][35], VEC[i][34], VEC[i][33]);
      check($sformatf("R11 vector %0d hit", i), 32'(hit_o), 32'(VEC[i][32]));
      check($sformatf("R8 vector %0d pa", i), pa_o, VEC[i][31:0]);
    end

    // R4 flush pulse, R9 next index takes over
    spr_wr(10'd528, 32'h0);
    check("R4 flush high after write", 32'(flush_o), 32'h1);
    @(negedge clk_i);
    check("R4 flush one cycle", 32'(flush_o), 32'h0);
    look(32'h0001_2ABC, 1'b0, 1'b0, 1'b1);
    check("R9 index 1 before 4", pa_o, 32'h3001_2000);

    // R12 write and lookup in the same cycle
    @(negedge clk_i);
    spr_we_i = 1'b1; spr_num_i = 10'd536; spr_wdata_i = 32'h0;
    ea_i = 32'h8001_F123; side_i = 1'b1; user_i = 1'b1; xlate_en_i = 1'b1;
    @(negedge clk_i);
    spr_we_i = 1'b0;
    check("R12 old contents hit", 32'(hit_o), 32'h1);
    check("R12 old contents pa", pa_o, 32'h0401_F000);
    check("R12 flush with lookup", 32'(flush_o), 32'h1);
    @(negedge clk_i);
    check("R12 new contents miss", 32'(hit_o), 32'h0);

    // R3 outside the window (576 aliases instr 0 upper by low bits)
    spr_wr(10'd576, 32'hFFFF_FFFF);
    check("R3 no flush outside", 32'(flush_o), 32'h0);
    spr_rd(10'd576, rd); check("R3 outside reads zero", rd, 32'h0);
    spr_rd(10'd528, rd); check("R3 alias untouched", rd, 32'h0);
    spr_wr(10'd511, 32'hFFFF_FFFF);
    check("R3 no flush below window", 32'(flush_o), 32'h0);
    look(32'h0001_2ABC, 1'b0, 1'b0, 1'b1);
    check("R3 lookup unchanged", pa_o, 32'h3001_2000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule